// File: doc/BRIEF.md
# SMBus Bring-Up Register Writer

This block is a small bus master that configures one downstream device over a two-wire SMBus link. After reset is released, or when a start pulse arrives while it is idle, it plays a fixed bring-up program of nineteen single-byte register writes. First comes a register reset. Then come three groups of six per-lane writes: de-emphasis, equalization and output swing. Each write is a separate transaction.

The bus lines are driven only through drive-low enables, so the block fits an open-drain pad. Bit timing comes from a clock divider. Each bit is split into four quarter periods, and SDA moves only in the quarter where the clock line is held low. The block checks the acknowledge bit after every byte. On the first missing acknowledge it closes the bus with a STOP, raises an error flag, records which write failed and stops. If all writes are acknowledged, it raises a done flag.

Top module: `cfg_wr_seq`

## Requirements
- R1: While reset is high, both bus enables are 0 and busy, done and error are low. Once reset falls, the program starts without any start pulse.
- R2: The writes go out in a fixed order, as (register, data) by index:
  - index 0 is (0x00, 0x01);
  - indices 1 to 6 write 0x88 to 0x18, 0x26, 0x2E, 0x35, 0x3C, 0x43;
  - indices 7 to 12 write 0x30 to 0x0F, 0x16, 0x1D, 0x24, 0x2C, 0x3A;
  - indices 13 to 18 write 0x0F to 0x17, 0x25, 0x2D, 0x34, 0x3B, 0x42.
- R3: Each write is one transaction, in this order:
  - a START;
  - the byte {slave address, 0};
  - the register byte;
  - the data byte;
  - a STOP.
  Bytes are sent MSB first. SDA changes during a byte only while SCL is held low, so the slave sees exactly one START per write.
- R4: If the slave leaves SDA high in any acknowledge slot, the block sends a STOP and stops. It then sets error high, with err_idx_o equal to the 0-based index of the failed write. No later write is attempted, and done stays low.
- R5: Done goes high, with busy low, only after all 19 writes have been acknowledged on every byte. Done and error are never high together.
- R6: A start pulse while idle reruns the whole program and clears done and error. A start pulse while busy is ignored, so no extra transaction follows the running program.
- R7: Between a STOP and the next START, both lines stay released for at least GAP divider periods.
- R8: The outputs are drive-low enables only. When idle, both enables are 0, which releases the bus.
- R9: The first byte of each write carries slv_addr_i. If no slave acknowledges that address, the error is reported with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to rerun the program |
| slv_addr_i | input | 7 | 7-bit slave address |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | All writes acknowledged |
| err_o | output | 1 | A write was not acknowledged |
| err_idx_o | output | 5 | Index of the failed write |

## Verification
The assertions check, on every cycle:
- SDA never moves during a byte while SCL is released;
- the bus is released whenever the block is idle or waiting in the gap;
- done and error exclude each other;
- the error index stays in range;
- flags are cleared when a new run begins.

Only the bench's scenarios can show the rest. A slave model decodes the bus and checks the register and data values and their order. It also counts START conditions, measures the idle gap and confirms that a NACK at a chosen write and byte cuts the program short at exactly that index.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int NWR  = 19;
  localparam int IDXW = $clog2(NWR);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GAP   = 3'd1,
    S_START = 3'd2,
    S_BIT   = 3'd3,
    S_STOP  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/cfgseq_rom.sv
module cfgseq_rom import cfgseq_pkg::*; (
  input  logic            clk,
  input  logic [IDXW-1:0] idx,
  output logic [7:0]      reg_q,
  output logic [7:0]      dat_q
);
  // registered read so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    case (idx)
      5'd0:    begin reg_q <= 8'h00; dat_q <= 8'h01; end
      5'd1:    begin reg_q <= 8'h18; dat_q <= 8'h88; end
      5'd2:    begin reg_q <= 8'h26; dat_q <= 8'h88; end
      5'd3:    begin reg_q <= 8'h2E; dat_q <= 8'h88; end
      5'd4:    begin reg_q <= 8'h35; dat_q <= 8'h88; end
      5'd5:    begin reg_q <= 8'h3C; dat_q <= 8'h88; end
      5'd6:    begin reg_q <= 8'h43; dat_q <= 8'h88; end
      5'd7:    begin reg_q <= 8'h0F; dat_q <= 8'h30; end
      5'd8:    begin reg_q <= 8'h16; dat_q <= 8'h30; end
      5'd9:    begin reg_q <= 8'h1D; dat_q <= 8'h30; end
      5'd10:   begin reg_q <= 8'h24; dat_q <= 8'h30; end
      5'd11:   begin reg_q <= 8'h2C; dat_q <= 8'h30; end
      5'd12:   begin reg_q <= 8'h3A; dat_q <= 8'h30; end
      5'd13:   begin reg_q <= 8'h17; dat_q <= 8'h0F; end
      5'd14:   begin reg_q <= 8'h25; dat_q <= 8'h0F; end
      5'd15:   begin reg_q <= 8'h2D; dat_q <= 8'h0F; end
      5'd16:   begin reg_q <= 8'h34; dat_q <= 8'h0F; end
      5'd17:   begin reg_q <= 8'h3B; dat_q <= 8'h0F; end
      5'd18:   begin reg_q <= 8'h42; dat_q <= 8'h0F; end
      default: begin reg_q <= 8'h00; dat_q <= 8'h00; end
    endcase
  end
endmodule

// File: rtl/cfgseq_tick.sv
module cfgseq_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_wr_seq.sv
module cfg_wr_seq import cfgseq_pkg::*; #(
  parameter int DIV = 64,
  parameter int GAP = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [6:0]      slv_addr_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [IDXW-1:0] err_idx_o
);
  localparam int GW = $clog2(GAP + 1);

  seq_st_t         st;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic [1:0]      bytn;
  logic [IDXW-1:0] widx;
  logic [GW-1:0]   gcnt;
  logic            pend, nack, tick;
  logic [7:0]      rom_reg, rom_dat, cur;

  cfgseq_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));
  cfgseq_rom u_rom (.clk(clk), .idx(widx), .reg_q(rom_reg), .dat_q(rom_dat));

  always_comb begin
    case (bytn)
      2'd0:    cur = {slv_addr_i, 1'b0};
      2'd1:    cur = rom_reg;
      default: cur = rom_dat;
    endcase
  end

  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; q <= '0; bitn <= '0; bytn <= '0; widx <= '0; gcnt <= '0;
      pend <= 1'b1; nack <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0; err_idx_o <= '0;
    end else if (st == S_IDLE) begin
      if (pend || start_i) begin
        st <= S_GAP; pend <= 1'b0; gcnt <= '0; widx <= '0; nack <= 1'b0;
        done_o <= 1'b0; err_o <= 1'b0;
      end
    end else if (tick) begin
      case (st)
        S_GAP: begin
          scl_oe <= 1'b0; sda_oe <= 1'b0;
          if (gcnt == GW'(GAP - 1)) begin st <= S_START; q <= '0; end
          else gcnt <= gcnt + 1'b1;
        end
        S_START: begin
          q <= q + 1'b1;
          if (q == 2'd1) sda_oe <= 1'b1;
          if (q == 2'd3) begin
            scl_oe <= 1'b1; st <= S_BIT; bitn <= '0; bytn <= '0;
          end
        end
        S_BIT: begin
          q <= q + 1'b1;
          case (q)
            2'd0: scl_oe <= 1'b1;
            2'd1: sda_oe <= (bitn == 4'd8) ? 1'b0 : ~cur[~bitn[2:0]];
            2'd2: scl_oe <= 1'b0;
            default: begin
              if (bitn == 4'd8) begin
                bitn <= '0;
                if (sda_i) begin nack <= 1'b1; st <= S_STOP; end
                else if (bytn == 2'd2) st <= S_STOP;
                else bytn <= bytn + 1'b1;
              end else bitn <= bitn + 1'b1;
            end
          endcase
        end
        S_STOP: begin
          q <= q + 1'b1;
          case (q)
            2'd0: scl_oe <= 1'b1;
            2'd1: sda_oe <= 1'b1;
            2'd2: scl_oe <= 1'b0;
            default: begin
              sda_oe <= 1'b0;
              if (nack) begin
                st <= S_IDLE; err_o <= 1'b1; err_idx_o <= widx;
              end else if (widx == IDXW'(NWR - 1)) begin
                st <= S_IDLE; done_o <= 1'b1;
              end else begin
                widx <= widx + 1'b1; st <= S_GAP; gcnt <= '0;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: during a byte, SDA moves only with SCL held low before and after
  a_r3_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
    (st == S_BIT && $past(st) == S_BIT && sda_oe != $past(sda_oe)) |-> (scl_oe && $past(scl_oe)));
  // R5: done excludes error and busy
  a_r5_done_clean: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!err_o && !busy_o));
  // R4: failed index lies inside the program
  a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (err_idx_o < IDXW'(NWR)));
  // R6: a newly accepted run begins with both flags cleared
  a_r6_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    (st == S_GAP && $past(st) == S_IDLE) |-> (!done_o && !err_o));
  // R8: idle means a released bus
  a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe));
  // R7: lines stay released throughout the gap
  a_r7_gap_released: assert property (@(posedge clk) disable iff (rst)
    (st == S_GAP) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_cfg_wr_seq.sv
`timescale 1ns/1ps
module tb_cfg_wr_seq;
  localparam int DIV = 4;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [6:0] addr_i = 7'h50;
  logic scl_oe, sda_oe, busy_o, done_o, err_o;
  logic [4:0] err_idx_o;

  logic slv_low = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | slv_low);

  always #2 clk = ~clk;

  cfg_wr_seq #(.DIV(DIV), .GAP(GAP)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .slv_addr_i(addr_i), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .err_idx_o(err_idx_o));

  int n_chk = 0, n_bad = 0;

  // slave model configuration (written by the stimulus)
  logic [6:0] slv_addr = 7'h50;
  int nack_w = -1, nack_b = 0;
  logic clr_req = 1'b0;

  // slave model state (written only by the slave process)
  logic clr_seen = 1'b0;
  logic ps = 1'b1, pd = 1'b1, in_x = 1'b0, rej = 1'b0, ok;
  int bitc = 0, bytec = 0, nwr = 0, starts = 0, have_stop = 0;
  longint min_gap = 64'd1000000000, last_stop = 0, g;
  logic [7:0] sh = 8'h00;
  logic [7:0] bb [3];
  logic [7:0] log_reg [32];
  logic [7:0] log_dat [32];

  always @(scl_w, sda_w, clr_req) begin
    if (clr_req !== clr_seen) begin
      clr_seen = clr_req; nwr = 0; starts = 0; have_stop = 0;
      min_gap = 64'd1000000000; in_x = 1'b0; slv_low = 1'b0;
    end else if (scl_w === 1'b1 && ps === 1'b1 && pd === 1'b1 && sda_w === 1'b0) begin
      in_x = 1'b1; rej = 1'b0; bitc = 0; bytec = 0; starts++;
      if (have_stop != 0) begin
        g = ($time - last_stop) / 4;
        if (g < min_gap) min_gap = g;
      end
    end else if (scl_w === 1'b1 && ps === 1'b1 && pd === 1'b0 && sda_w === 1'b1 && in_x) begin
      in_x = 1'b0; last_stop = $time; have_stop = 1;
      if (!rej && bytec == 3) begin
        log_reg[nwr] = bb[1]; log_dat[nwr] = bb[2]; nwr++;
      end
    end else if (ps === 1'b0 && scl_w === 1'b1 && in_x && bitc < 8) begin
      sh = {sh[6:0], sda_w}; bitc++;
    end else if (ps === 1'b1 && scl_w === 1'b0 && in_x) begin
      if (bitc == 8) begin
        if (bytec < 3) bb[bytec] = sh;
        if (bytec == 0) ok = (sh == {slv_addr, 1'b0});
        else ok = !(nwr == nack_w && bytec == nack_b);
        if (!ok) rej = 1'b1;
        slv_low = ok; bitc = 9;
      end else if (bitc == 9) begin
        slv_low = 1'b0; bitc = 0; bytec++;
      end
    end
    ps = scl_w; pd = sda_w;
  end

  function automatic logic [7:0] exp_reg(input int i);
    logic [7:0] de [6] = '{8'h18, 8'h26, 8'h2E, 8'h35, 8'h3C, 8'h43};
    logic [7:0] eq [6] = '{8'h0F, 8'h16, 8'h1D, 8'h24, 8'h2C, 8'h3A};
    logic [7:0] vd [6] = '{8'h17, 8'h25, 8'h2D, 8'h34, 8'h3B, 8'h42};
    if (i == 0) return 8'h00;
    if (i <= 6) return de[i-1];
    if (i <= 12) return eq[i-7];
    return vd[i-13];
  endfunction

  function automatic logic [7:0] exp_dat(input int i);
    if (i == 0) return 8'h01;
    if (i <= 6) return 8'h88;
    if (i <= 12) return 8'h30;
    return 8'h0F;
  endfunction

  task automatic chk(input bit good, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_end();
    repeat (4) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_run();
    clr_req = ~clr_req;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_end();
  endtask

  task automatic check_log(input int n);
    for (int i = 0; i < n; i++)
      chk(log_reg[i] == exp_reg(i) && log_dat[i] == exp_dat(i), "R2",
          {log_reg[i], log_dat[i]}, {exp_reg(i), exp_dat(i)});
  endtask

  task automatic check_ok_run();
    chk(done_o && !err_o, "R5", {done_o, err_o}, 2'b10);
    chk(nwr == 19, "R5 write count", nwr, 19);
    check_log(19);
    chk(starts == 19, "R3 start count", starts, 19);
    chk(min_gap >= GAP * DIV, "R7 gap clocks", min_gap, GAP * DIV);
    chk(!scl_oe && !sda_oe, "R8 released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic check_err_run(input int w);
    chk(err_o && !done_o, "R4 flags", {done_o, err_o}, 2'b01);
    chk(err_idx_o == w, "R4 index", err_idx_o, w);
    chk(nwr == w, "R4 writes before abort", nwr, w);
    chk(starts == w + 1, "R4 no later write", starts, w + 1);
    check_log(w);
    chk(!scl_oe && !sda_oe, "R8 released after abort", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R5 actual=%0h expected=%0h", busy_o, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy_o && !done_o && !err_o, "R1 reset state",
        {scl_oe, sda_oe, busy_o, done_o, err_o}, 0);
    rst = 1'b0;
    // R1: run starts on its own after reset
    wait_end();
    check_ok_run();

    // R6: start while busy is ignored
    clr_req = ~clr_req;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (3000) @(negedge clk);
    chk(busy_o, "R6 still busy", busy_o, 1);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_end();
    repeat (2000) @(negedge clk);
    check_ok_run();
    chk(!busy_o, "R6 no rerun", busy_o, 0);

    // R4 random NACK positions, R9 random addresses
    for (int k = 0; k < 4; k++) begin
      addr_i = 7'($urandom % 128); slv_addr = addr_i;
      nack_w = int'($urandom % 19); nack_b = 1 + int'($urandom % 2);
      do_run();
      check_err_run(nack_w);
    end

    // R6: a clean rerun clears the error flag
    nack_w = -1;
    do_run();
    check_ok_run();

    // R9: address mismatch fails at index 0
    slv_addr = addr_i ^ 7'h01;
    do_run();
    check_err_run(0);
    slv_addr = addr_i;

    // R4: last data byte rejected
    nack_w = 18; nack_b = 2;
    do_run();
    check_err_run(18);

    // R9: another address, full success
    nack_w = -1; addr_i = 7'h2B; slv_addr = 7'h2B;
    do_run();
    check_ok_run();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule